// File: doc/BRIEF.md
# Bit-Serial Link Endpoint with Early Acknowledge

This block is one end of a point-to-point serial link. It has one output wire and one input wire, and both wires idle low. On the output wire it sends two kinds of packet: data packets that carry one byte each, and short acknowledge packets. On the input wire it decodes the same two kinds of packet. Words to transmit come from a memory-fetch port with a valid/ready handshake. The block keeps a current word and a prefetched next word, and it sends their bytes in order, low byte first. Received bytes are packed into words. One complete word can wait in a spare register, offered on a write port, while the next word is being assembled.

Flow control allows one unacknowledged byte in flight. The receiver decides to acknowledge a byte when it samples that byte's fifth bit, not after the stop bit. The acknowledge therefore leaves at the next packet boundary on the output wire, and acknowledges take priority over data at that boundary. The peer can then start its next byte directly after its current stop bit. The receiver gives this early acknowledge only if there will still be room for one more byte after the current one is stored. Otherwise the acknowledge is held until the write port drains the spare word.

Both directions run in one clock domain. Each bit period lasts `BIT_CYCLES` clocks, and the receiver samples each bit near its middle.

Top module: `slink_endpoint`

## Requirements
- R1: After a synchronous reset, `ser_out` is low, `wr_valid` is low and `fetch_ready` is high.
- R2: A data packet lasts 11 bit periods of `BIT_CYCLES` clocks each. The bits are 1, 1, the eight data bits with the least significant bit first, then 0. The bytes of a fetched word go out in the order bits 7:0, 15:8, 23:16, 31:24.
- R3: An acknowledge packet lasts 2 bit periods: 1 then 0. The receiver tells it apart from a data packet by the value of the second bit.
- R4: At most one data byte is unacknowledged. After the first byte following reset, a new data packet starts only after an acknowledge packet has been received since the previous data packet started.
- R5: The acknowledge decision is made at the fifth bit of an incoming data packet. A pending acknowledge is sent ahead of any data at the next packet boundary. In loopback, every data packet after the first is therefore directly preceded by an acknowledge.
- R6: When an acknowledge is received before the current packet ends and bytes are available, packets follow each other with no idle bit periods. In loopback, consecutive data packets start exactly 13 bit periods apart, across word boundaries as well.
- R7: The transmit side holds two words. `fetch_ready` is high exactly when the second (prefetch) word slot is empty, and a word is taken on a cycle where both `fetch_valid` and `fetch_ready` are high.
- R8: Four received bytes form one word, with the first received byte in bits 7:0. The word is offered on `wr_valid`/`wr_data` and held stable until `wr_ready` accepts it.
- R9: Receive storage holds 8 bytes: the word being assembled plus the spare word. An acknowledge is withheld while storing the current byte would leave no room for one more. With `wr_ready` held low from an empty state, exactly 8 data packets arrive and 7 acknowledges are sent before the link stalls.
- R10: When the spare word is accepted and room appears, the withheld acknowledge goes out, transfer resumes, and every byte is delivered in order with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| ser_out | output | 1 | Serial output wire, idle low |
| ser_in | input | 1 | Serial input wire, idle low |
| fetch_valid | input | 1 | Memory side offers a word to transmit |
| fetch_ready | output | 1 | Prefetch word slot is empty |
| fetch_data | input | 8*WORD_BYTES | Word to transmit |
| wr_valid | output | 1 | Spare word holds a received word |
| wr_ready | input | 1 | Memory side accepts the received word |
| wr_data | output | 8*WORD_BYTES | Received word, first byte in the low lane |

## Verification
The embedded assertions check on every cycle that the receiver never stores a byte when both word slots are full, and that a new data packet never arrives while an acknowledge is still owed or a byte is still pending. They also check that no acknowledge shows up while the transmitter already holds its credit, that the serialiser takes a byte only when one is buffered, and that a word on the write port stays put until it is taken. Other behaviour can only be shown by the loopback scenarios. These are the exact bit pattern on the wire, the strict alternation of data and acknowledge packets, and the 13-bit-period spacing that proves there are no gaps. They also cover the count of 8 bytes before the stall under write back-pressure, the blocked prefetch during that stall, and in-order delivery once the link resumes.

// File: rtl/slink_pkg.sv
`timescale 1ns/1ps
package slink_pkg;
  localparam int BYTE_BITS     = 8;
  localparam int DATA_PKT_LEN  = 11;
  localparam int ACK_PKT_LEN   = 2;
  // Absolute bit index (start = 0) at which the receive side decides the acknowledge.
  localparam int EARLY_ACK_BIT = 4;
  localparam int LAST_DATA_BIT = 9;
  localparam int STOP_BIT      = 10;

  // Time order: element 0 leaves first.
  function automatic logic [DATA_PKT_LEN-1:0] make_data_pkt(input logic [BYTE_BITS-1:0] b);
    return {1'b0, b, 2'b11};
  endfunction
endpackage

// File: rtl/slink_txq.sv
`timescale 1ns/1ps
module slink_txq #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fetch_valid,
  input  logic [8*WORD_BYTES-1:0] fetch_data,
  output logic                    fetch_ready,
  output logic                    byte_valid,
  output logic [7:0]              byte_data,
  input  logic                    byte_take
);
  localparam int W  = 8 * WORD_BYTES;
  localparam int IW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic [W-1:0]  cur_q, nxt_q;
  logic          cur_v, nxt_v;
  logic [IW-1:0] idx;
  logic [7:0]    lane [WORD_BYTES];
  logic          take_last, cur_free;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lane[g] = cur_q[8*g +: 8];
  end

  assign take_last   = byte_take && (idx == IW'(WORD_BYTES-1));
  assign cur_free    = !cur_v || take_last;
  assign fetch_ready = !nxt_v;
  assign byte_valid  = cur_v;
  assign byte_data   = lane[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v <= 1'b0;
      nxt_v <= 1'b0;
      idx   <= '0;
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      if (byte_take) idx <= take_last ? '0 : idx + 1'b1;
      if (cur_free) begin
        cur_v <= nxt_v;
        if (nxt_v) cur_q <= nxt_q;
      end
      if (fetch_valid && !nxt_v) begin
        nxt_q <= fetch_data;
        nxt_v <= 1'b1;
      end else if (cur_free && nxt_v) begin
        nxt_v <= 1'b0;
      end
    end
  end

  assert_take_buffered_R7: assert property (@(posedge clk) disable iff (rst)
    byte_take |-> byte_valid);
endmodule

// File: rtl/slink_txser.sv
`timescale 1ns/1ps
module slink_txser
  import slink_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       byte_take,
  input  logic       ack_req,
  output logic       ack_go,
  input  logic       ack_rx,
  output logic       ser_out
);
  localparam int TW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [TW-1:0] TMAX = TW'(BIT_CYCLES - 1);

  logic [TW-1:0]           tmr;
  logic [3:0]              left;
  logic [DATA_PKT_LEN-1:0] sh;
  logic [DATA_PKT_LEN-1:0] pkt;
  logic                    busy, credit, boundary;

  assign boundary  = !busy || (tmr == '0 && left == '0);
  assign ack_go    = boundary && ack_req;
  assign byte_take = boundary && !ack_req && credit && byte_valid;
  assign pkt       = make_data_pkt(byte_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ser_out <= 1'b0;
      sh      <= '0;
      left    <= '0;
      tmr     <= '0;
      credit  <= 1'b1;
    end else begin
      credit <= (credit && !byte_take) || ack_rx;
      if (boundary) begin
        if (ack_go) begin
          ser_out <= 1'b1;
          sh      <= '0;
          left    <= 4'(ACK_PKT_LEN - 1);
          tmr     <= TMAX;
          busy    <= 1'b1;
        end else if (byte_take) begin
          ser_out <= pkt[0];
          sh      <= {1'b0, pkt[DATA_PKT_LEN-1:1]};
          left    <= 4'(DATA_PKT_LEN - 1);
          tmr     <= TMAX;
          busy    <= 1'b1;
        end else begin
          ser_out <= 1'b0;
          busy    <= 1'b0;
        end
      end else if (tmr == '0) begin
        ser_out <= sh[0];
        sh      <= sh >> 1;
        left    <= left - 1'b1;
        tmr     <= TMAX;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  assert_ack_solicited_R4: assert property (@(posedge clk) disable iff (rst)
    ack_rx |-> !credit);
endmodule

// File: rtl/slink_rxdes.sv
`timescale 1ns/1ps
module slink_rxdes
  import slink_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_in,
  output logic       ack_rx,
  output logic       byte_start,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int TW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [TW-1:0] TMAX  = TW'(BIT_CYCLES - 1);
  localparam logic [TW-1:0] THALF = TW'(BIT_CYCLES / 2 - 1);

  logic          rin, run;
  logic [TW-1:0] tmr;
  logic [3:0]    bidx;
  logic [7:0]    shb;

  always_ff @(posedge clk) begin
    if (rst) begin
      rin        <= 1'b0;
      run        <= 1'b0;
      tmr        <= '0;
      bidx       <= '0;
      shb        <= '0;
      rx_byte    <= '0;
      ack_rx     <= 1'b0;
      byte_start <= 1'b0;
      byte_done  <= 1'b0;
    end else begin
      rin        <= ser_in;
      ack_rx     <= 1'b0;
      byte_start <= 1'b0;
      byte_done  <= 1'b0;
      if (!run) begin
        if (rin) begin
          run  <= 1'b1;
          tmr  <= THALF;
          bidx <= '0;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        tmr  <= TMAX;
        bidx <= bidx + 1'b1;
        if (bidx == 4'd1 && !rin) begin
          ack_rx <= 1'b1;
          run    <= 1'b0;
        end
        if (bidx >= 4'd2 && bidx <= 4'(LAST_DATA_BIT)) shb <= {rin, shb[7:1]};
        if (bidx == 4'(EARLY_ACK_BIT)) byte_start <= 1'b1;
        if (bidx == 4'(LAST_DATA_BIT)) begin
          byte_done <= 1'b1;
          rx_byte   <= {rin, shb[7:1]};
        end
        if (bidx == 4'(STOP_BIT)) run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slink_rxq.sv
`timescale 1ns/1ps
module slink_rxq #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_start,
  input  logic                    byte_done,
  input  logic [7:0]              rx_byte,
  input  logic                    ack_go,
  output logic                    ack_req,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [8*WORD_BYTES-1:0] wr_data
);
  localparam int W   = 8 * WORD_BYTES;
  localparam int CAP = 2 * WORD_BYTES;
  localparam int AW  = $clog2(WORD_BYTES + 1);
  localparam int CW  = $clog2(CAP + 2);

  logic [W-1:0]  asm_word, spare;
  logic [AW-1:0] acnt, lane_sel;
  logic          sp_v, owe, pend;
  logic          drain, full_asm, move;
  logic [CW-1:0] occ;

  assign drain    = sp_v && wr_ready;
  assign full_asm = (acnt == AW'(WORD_BYTES));
  assign move     = full_asm && (!sp_v || drain);
  assign lane_sel = move ? '0 : acnt;
  assign occ      = CW'(acnt) + (sp_v ? CW'(WORD_BYTES) : '0) + CW'(pend);
  assign ack_req  = owe && (occ < CW'(CAP));
  assign wr_valid = sp_v;
  assign wr_data  = spare;

  always_ff @(posedge clk) begin
    if (rst) begin
      acnt  <= '0;
      sp_v  <= 1'b0;
      owe   <= 1'b0;
      pend  <= 1'b0;
      spare <= '0;
    end else begin
      owe  <= byte_start || (owe && !ack_go);
      pend <= byte_start || (pend && !byte_done);
      if (byte_done)  acnt <= lane_sel + 1'b1;
      else if (move)  acnt <= '0;
      if (move) begin
        spare <= asm_word;
        sp_v  <= 1'b1;
      end else if (drain) begin
        sp_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < WORD_BYTES; l++)
      if (byte_done && lane_sel == AW'(l)) asm_word[8*l +: 8] <= rx_byte;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (!full_asm || move));
  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
    byte_start |-> (!owe && !pend));
  assert_word_held_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
endmodule

// File: rtl/slink_endpoint.sv
`timescale 1ns/1ps
module slink_endpoint #(
  parameter int BIT_CYCLES = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    ser_out,
  input  logic                    ser_in,
  input  logic                    fetch_valid,
  output logic                    fetch_ready,
  input  logic [8*WORD_BYTES-1:0] fetch_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [8*WORD_BYTES-1:0] wr_data
);
  logic       byte_valid, byte_take, ack_req, ack_go, ack_rx;
  logic       byte_start, byte_done;
  logic [7:0] byte_data, rx_byte;

  slink_txq #(.WORD_BYTES(WORD_BYTES)) u_txq (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_take(byte_take)
  );

  slink_txser #(.BIT_CYCLES(BIT_CYCLES)) u_txser (
    .clk(clk), .rst(rst),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_take(byte_take),
    .ack_req(ack_req), .ack_go(ack_go), .ack_rx(ack_rx), .ser_out(ser_out)
  );

  slink_rxdes #(.BIT_CYCLES(BIT_CYCLES)) u_rxdes (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .ack_rx(ack_rx), .byte_start(byte_start), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  slink_rxq #(.WORD_BYTES(WORD_BYTES)) u_rxq (
    .clk(clk), .rst(rst),
    .byte_start(byte_start), .byte_done(byte_done), .rx_byte(rx_byte),
    .ack_go(ack_go), .ack_req(ack_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
  );
endmodule

// File: tb/slink_endpoint_bench.sv
`timescale 1ns/1ps
module slink_endpoint_bench;
  localparam int BC = 16;
  localparam int WB = 4;
  localparam int W  = 8 * WB;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         line_w;
  logic         fetch_valid = 1'b0;
  logic         fetch_ready;
  logic [W-1:0] fetch_data = '0;
  logic         wr_valid;
  logic         wr_ready = 1'b1;
  logic [W-1:0] wr_data;

  always #2.5 clk = ~clk;

  slink_endpoint #(.BIT_CYCLES(BC), .WORD_BYTES(WB)) u_slink_endpoint (
    .clk(clk), .rst(rst), .ser_out(line_w), .ser_in(line_w),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
  );

  logic [W-1:0] fetch_q[$];
  logic [W-1:0] exp_words[$];
  logic [7:0]   exp_bytes[$];
  int n_chk = 0, n_err = 0, cyc = 0;
  int data_cnt = 0, ack_cnt = 0, last_start = 0;
  bit last_was_ack = 0, in_phase1 = 1, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_word(input logic [W-1:0] w);
    fetch_q.push_back(w);
    exp_words.push_back(w);
    for (int b = 0; b < WB; b++) exp_bytes.push_back(w[8*b +: 8]);
  endtask

  // Fetch driver
  initial begin
    forever begin
      @(posedge clk); #1;
      fetch_valid = (fetch_q.size() > 0);
      if (fetch_valid) fetch_data = fetch_q[0];
      @(negedge clk);
      if (fetch_valid && fetch_ready) void'(fetch_q.pop_front());
    end
  end

  // Write-port monitor (scoreboard)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && wr_valid && wr_ready) begin
        if (exp_words.size() == 0) check(0, "R10", "unexpected word", wr_data, '0);
        else begin
          logic [W-1:0] e;
          e = exp_words.pop_front();
          check(wr_data == e, "R8", "received word", wr_data, e);
        end
      end
    end
  end

  // Independent wire decoder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && line_w) begin
        int st;
        logic b1;
        logic [7:0] d;
        st = cyc;
        repeat (BC/2) @(negedge clk);
        repeat (BC) @(negedge clk);
        b1 = line_w;
        if (!b1) begin
          ack_cnt++;
          last_was_ack = 1;
        end else begin
          for (int i = 0; i < 8; i++) begin
            repeat (BC) @(negedge clk);
            d[i] = line_w;
          end
          repeat (BC) @(negedge clk);
          check(line_w == 1'b0, "R2", "stop bit", W'(line_w), '0);
          if (exp_bytes.size() == 0) check(0, "R2", "extra data byte", W'(d), '0);
          else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(d == e, "R2", "wire byte", W'(d), W'(e));
          end
          if (data_cnt > 0)
            check(last_was_ack, "R5", "ack precedes data", W'(last_was_ack), W'(1));
          if (data_cnt > 0)
            check(ack_cnt >= data_cnt, "R4", "acks before data", W'(ack_cnt), W'(data_cnt));
          if (in_phase1 && data_cnt > 0 && data_cnt < 12)
            check(st - last_start == 13*BC, "R6", "data start spacing",
                  W'(st - last_start), W'(13*BC));
          last_start = st;
          last_was_ack = 0;
          data_cnt++;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(line_w == 1'b0, "R1", "ser_out after reset", W'(line_w), '0);
    check(wr_valid == 1'b0, "R1", "wr_valid after reset", W'(wr_valid), '0);
    check(fetch_ready == 1'b1, "R1", "fetch_ready after reset", W'(fetch_ready), W'(1));

    // Phase 1: free-flowing loopback, 12 bytes
    push_word(32'hFF00A55A);
    push_word(32'h01807F3C);
    push_word(32'h12345678);
    while (!(data_cnt == 12 && ack_cnt == 12 && exp_words.size() == 0)) @(negedge clk);
    check(ack_cnt == data_cnt, "R3", "ack packets counted", W'(ack_cnt), W'(data_cnt));
    check(exp_bytes.size() == 0, "R2", "all bytes seen", W'(exp_bytes.size()), '0);
    repeat (4) @(negedge clk);
    check(fetch_ready == 1'b1, "R7", "prefetch slot empty when idle", W'(fetch_ready), W'(1));

    // Phase 2: write back-pressure
    in_phase1 = 0;
    @(posedge clk); #1 wr_ready = 1'b0;
    push_word(32'hC3C30F0F);
    push_word(32'h00000000);
    push_word(32'hDEADBEEF);
    push_word(32'h80402010);
    while (data_cnt < 20) @(negedge clk);
    repeat (40*BC) @(negedge clk);
    check(data_cnt == 20, "R9", "bytes sent before stall", W'(data_cnt), W'(20));
    check(ack_cnt == 19, "R9", "acks sent before stall", W'(ack_cnt), W'(19));
    check(wr_valid == 1'b1, "R8", "word offered during stall", W'(wr_valid), W'(1));
    check(wr_data == 32'hC3C30F0F, "R8", "held word", wr_data, 32'hC3C30F0F);
    check(fetch_ready == 1'b0, "R7", "both word slots held", W'(fetch_ready), '0);
    repeat (5*BC) @(negedge clk);
    check(wr_data == 32'hC3C30F0F, "R8", "word stable", wr_data, 32'hC3C30F0F);
    check(line_w == 1'b0, "R9", "wire idle in stall", W'(line_w), '0);

    @(posedge clk); #1 wr_ready = 1'b1;
    while (!(data_cnt == 28 && ack_cnt == 28 && exp_words.size() == 0)) @(negedge clk);
    check(exp_bytes.size() == 0, "R10", "all bytes after resume", W'(exp_bytes.size()), '0);
    check(ack_cnt == 28, "R10", "withheld ack released", W'(ack_cnt), W'(28));
    repeat (4) @(negedge clk);
    check(wr_valid == 1'b0, "R10", "no extra word", W'(wr_valid), '0);
    done = 1;
    finish_run();
  end
endmodule